// File: doc/BRIEF.md
# Max Pooling Engine with Argmax Gradient Return

This block reduces a stored two-dimensional feature map with non-overlapping K×K max pooling. For every pooled output it also records the flat address of the input element that won the comparison, so the same block can later send gradients back to the positions that produced each maximum. A host fills an input-map RAM and a pooled-gradient RAM through one load port. It selects forward or backward operation, pulses a start strobe and waits for a single-cycle done pulse.

In a forward pass the engine walks each output's window and keeps a running maximum that starts from the fixed value −999. It writes the winner's value and flat address into the pooled-value memory and the location memory. In a backward pass it first zeroes every cell of a full-size gradient map. It then reads each pooled gradient together with its stored location and writes the gradient to that address. The host can read the pooled values, the locations and the expanded gradient map at any time through synchronous read ports. The pooled and location ports stay independent of a running backward pass.

Top module: `maxpool_argmax`

## Requirements
- R1: With the map loaded at address col·H+row (ld_sel=0), after a forward pass the pooled value at read address i·(H/K)+j is the maximum of columns i·K..i·K+K−1 and rows j·K..j·K+K−1 (signed 16-bit).
- R2: After a forward pass the location read at address i·(H/K)+j is the flat address col·H+row of the winning element of that window, always below W·H.
- R3: The window is scanned column by column, with rows inner. A later element replaces the running maximum only when strictly greater, so on equal values the earliest scanned element is reported.
- R4: The running maximum starts at −999 for every window. A window whose elements are all ≤ −999 yields −999, with the location of the window's first scanned element (col i·K, row j·K).
- R5: A backward pass (mode=1) writes zero to all W·H gradient cells before any gradient is scattered, so no cell keeps a value from an earlier pass unless it is a recorded location.
- R6: After a backward pass the gradient cell at location p equals the pooled gradient loaded at address p (ld_sel=1), for every output p.
- R7: busy rises the cycle after an accepted start and stays high until done. done is a one-cycle pulse that comes in the cycle busy falls. A start while busy is ignored.
- R8: While reset is held, busy and done are low in the following cycle.
- R9: During a backward pass, the pooled-value and location read ports return the results of the last forward pass.
- R10: Every read port delivers data for an address at the first rising edge after the address is applied, and holds it until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Load write strobe |
| ld_sel | input | 1 | Load target: 0 input map, 1 pooled gradient |
| ld_addr | input | AW | Load address |
| ld_data | input | DW | Load data, signed |
| mode | input | 1 | 0 forward pooling, 1 backward scatter |
| start | input | 1 | Start strobe, accepted when idle |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle completion pulse |
| pool_raddr | input | PAW | Read address for pooled value and location |
| pool_q | output | DW | Pooled value |
| loc_q | output | LW | Recorded winner address |
| grad_raddr | input | AW | Read address for the expanded gradient |
| grad_q | output | DW | Expanded gradient value |

## Verification
The host read of the pooled-value and location ports can fall in the same cycle as the backward engine's read of the location memory. The bench provokes this by stepping pool_raddr through every output on each cycle of a backward pass. Each returned value must equal the model's forward result for the address applied one cycle earlier. A second start strobe during every pass also tests that a strobe landing inside a run leaves exactly one done pulse.

// File: rtl/mp_pkg.sv
package mp_pkg;
  typedef enum logic [1:0] {BW_IDLE, BW_CLEAR, BW_SPREAD} bw_phase_t;
  localparam int FLOOR_VAL = -999;
endpackage

// File: rtl/mp_ram.sv
module mp_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 16,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mp_fwd_scan.sv
module mp_fwd_scan #(
  parameter int W   = 8,
  parameter int H   = 8,
  parameter int K   = 2,
  parameter int DW  = 16,
  parameter int LW  = 16,
  parameter int AW  = 6,
  parameter int PAW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  output logic [AW-1:0]  src_raddr,
  input  logic [DW-1:0]  src_rdata,
  output logic           out_we,
  output logic [PAW-1:0] out_addr,
  output logic [DW-1:0]  out_val,
  output logic [LW-1:0]  out_loc,
  output logic           fin
);
  localparam int OW = W / K;
  localparam int OH = H / K;
  localparam logic signed [DW-1:0] FLOOR = DW'(mp_pkg::FLOOR_VAL);

  logic run;
  int   oi, oj, wc, wr;
  int   col, row;
  logic w_first, w_last, all_last;

  // stage 1: address issued, data arrives next cycle
  logic           s1_v, s1_first, s1_last, s1_final;
  logic [LW-1:0]  s1_idx;
  logic [PAW-1:0] s1_oaddr;

  logic signed [DW-1:0] run_max, base_max, nmax;
  logic [LW-1:0]        run_loc, base_loc, nloc;
  logic                 take;

  always_comb begin
    col       = oi * K + wc;
    row       = oj * K + wr;
    src_raddr = AW'(col * H + row);
    w_first   = (wc == 0) && (wr == 0);
    w_last    = (wc == K - 1) && (wr == K - 1);
    all_last  = w_last && (oi == OW - 1) && (oj == OH - 1);
  end

  always_comb begin
    base_max = s1_first ? FLOOR  : run_max;
    base_loc = s1_first ? s1_idx : run_loc;
    take     = $signed(src_rdata) > base_max;
    nmax     = take ? $signed(src_rdata) : base_max;
    nloc     = take ? s1_idx : base_loc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      oi       <= 0;
      oj       <= 0;
      wc       <= 0;
      wr       <= 0;
      s1_v     <= 1'b0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
      s1_final <= 1'b0;
      s1_idx   <= '0;
      s1_oaddr <= '0;
      run_max  <= '0;
      run_loc  <= '0;
      out_we   <= 1'b0;
      out_addr <= '0;
      out_val  <= '0;
      out_loc  <= '0;
      fin      <= 1'b0;
    end else begin
      s1_v     <= run;
      s1_first <= w_first;
      s1_last  <= w_last;
      s1_final <= all_last;
      s1_idx   <= LW'(col * H + row);
      s1_oaddr <= PAW'(oi * OH + oj);

      if (go) begin
        run <= 1'b1;
        oi  <= 0;
        oj  <= 0;
        wc  <= 0;
        wr  <= 0;
      end else if (run) begin
        if (all_last) run <= 1'b0;
        if (wr == K - 1) begin
          wr <= 0;
          if (wc == K - 1) begin
            wc <= 0;
            if (oj == OH - 1) begin
              oj <= 0;
              oi <= oi + 1;
            end else begin
              oj <= oj + 1;
            end
          end else begin
            wc <= wc + 1;
          end
        end else begin
          wr <= wr + 1;
        end
      end

      if (s1_v) begin
        run_max <= nmax;
        run_loc <= nloc;
      end
      out_we   <= s1_v && s1_last;
      out_addr <= s1_oaddr;
      out_val  <= nmax;
      out_loc  <= nloc;
      fin      <= s1_v && s1_final;
    end
  end
endmodule

// File: rtl/mp_bwd_spread.sv
module mp_bwd_spread
  import mp_pkg::*;
#(
  parameter int W   = 8,
  parameter int H   = 8,
  parameter int K   = 2,
  parameter int DW  = 16,
  parameter int LW  = 16,
  parameter int AW  = 6,
  parameter int PAW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  output logic [PAW-1:0] lg_raddr,
  input  logic [LW-1:0]  loc_rdata,
  input  logic [DW-1:0]  gin_rdata,
  output logic           g_we,
  output logic [AW-1:0]  g_waddr,
  output logic [DW-1:0]  g_wdata,
  output logic           fin
);
  localparam int NPIX = W * H;
  localparam int NOUT = (W / K) * (H / K);

  bw_phase_t ph;
  int        cnt;
  logic      s_v, s_last;

  always_comb lg_raddr = PAW'(cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= BW_IDLE;
      cnt     <= 0;
      s_v     <= 1'b0;
      s_last  <= 1'b0;
      g_we    <= 1'b0;
      g_waddr <= '0;
      g_wdata <= '0;
      fin     <= 1'b0;
    end else begin
      s_v    <= 1'b0;
      s_last <= 1'b0;
      g_we   <= 1'b0;
      fin    <= 1'b0;
      case (ph)
        BW_IDLE: begin
          if (go) begin
            ph  <= BW_CLEAR;
            cnt <= 0;
          end
        end
        BW_CLEAR: begin
          g_we    <= 1'b1;
          g_waddr <= AW'(cnt);
          g_wdata <= '0;
          if (cnt == NPIX - 1) begin
            ph  <= BW_SPREAD;
            cnt <= 0;
          end else begin
            cnt <= cnt + 1;
          end
        end
        BW_SPREAD: begin
          s_v    <= 1'b1;
          s_last <= (cnt == NOUT - 1);
          if (cnt == NOUT - 1) begin
            ph  <= BW_IDLE;
            cnt <= 0;
          end else begin
            cnt <= cnt + 1;
          end
        end
        default: ph <= BW_IDLE;
      endcase

      if (s_v) begin
        g_we    <= (loc_rdata < LW'(NPIX));
        g_waddr <= AW'(loc_rdata);
        g_wdata <= gin_rdata;
        fin     <= s_last;
      end
    end
  end
endmodule

// File: rtl/maxpool_argmax.sv
module maxpool_argmax #(
  parameter  int W    = 8,
  parameter  int H    = 8,
  parameter  int K    = 2,
  parameter  int DW   = 16,
  parameter  int LW   = 16,
  localparam int NPIX = W * H,
  localparam int NOUT = (W / K) * (H / K),
  localparam int AW   = (NPIX > 1) ? $clog2(NPIX) : 1,
  localparam int PAW  = (NOUT > 1) ? $clog2(NOUT) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_we,
  input  logic           ld_sel,
  input  logic [AW-1:0]  ld_addr,
  input  logic [DW-1:0]  ld_data,
  input  logic           mode,
  input  logic           start,
  output logic           busy,
  output logic           done,
  input  logic [PAW-1:0] pool_raddr,
  output logic [DW-1:0]  pool_q,
  output logic [LW-1:0]  loc_q,
  input  logic [AW-1:0]  grad_raddr,
  output logic [DW-1:0]  grad_q
);
  logic go_f, go_b;
  logic [AW-1:0]  f_raddr;
  logic [DW-1:0]  src_q;
  logic           f_we, f_fin;
  logic [PAW-1:0] f_addr;
  logic [DW-1:0]  f_val;
  logic [LW-1:0]  f_loc;
  logic [PAW-1:0] b_raddr;
  logic [LW-1:0]  b_loc_q;
  logic [DW-1:0]  gin_q;
  logic           g_we, b_fin;
  logic [AW-1:0]  g_waddr;
  logic [DW-1:0]  g_wdata;

  always_comb begin
    go_f = start && !busy && !mode;
    go_b = start && !busy && mode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= f_fin || b_fin;
      if (go_f || go_b)      busy <= 1'b1;
      else if (f_fin || b_fin) busy <= 1'b0;
    end
  end

  mp_ram #(.DEPTH(NPIX), .DW(DW), .AW(AW)) u_src (
    .clk(clk), .we(ld_we && !ld_sel), .waddr(ld_addr), .wdata(ld_data),
    .raddr(f_raddr), .rdata(src_q));

  mp_ram #(.DEPTH(NOUT), .DW(DW), .AW(PAW)) u_gin (
    .clk(clk), .we(ld_we && ld_sel), .waddr(ld_addr[PAW-1:0]), .wdata(ld_data),
    .raddr(b_raddr), .rdata(gin_q));

  mp_ram #(.DEPTH(NOUT), .DW(DW), .AW(PAW)) u_pool (
    .clk(clk), .we(f_we), .waddr(f_addr), .wdata(f_val),
    .raddr(pool_raddr), .rdata(pool_q));

  // two identical location copies: copy 0 for the host, copy 1 for the scatter engine
  for (genvar c = 0; c < 2; c++) begin : g_loc
    logic [PAW-1:0] ra;
    logic [LW-1:0]  rq;
    assign ra = (c == 0) ? pool_raddr : b_raddr;
    mp_ram #(.DEPTH(NOUT), .DW(LW), .AW(PAW)) u_ram (
      .clk(clk), .we(f_we), .waddr(f_addr), .wdata(f_loc),
      .raddr(ra), .rdata(rq));
  end
  assign loc_q   = g_loc[0].rq;
  assign b_loc_q = g_loc[1].rq;

  mp_ram #(.DEPTH(NPIX), .DW(DW), .AW(AW)) u_grad (
    .clk(clk), .we(g_we), .waddr(g_waddr), .wdata(g_wdata),
    .raddr(grad_raddr), .rdata(grad_q));

  mp_fwd_scan #(.W(W), .H(H), .K(K), .DW(DW), .LW(LW), .AW(AW), .PAW(PAW)) u_fwd (
    .clk(clk), .rst(rst), .go(go_f), .src_raddr(f_raddr), .src_rdata(src_q),
    .out_we(f_we), .out_addr(f_addr), .out_val(f_val), .out_loc(f_loc), .fin(f_fin));

  mp_bwd_spread #(.W(W), .H(H), .K(K), .DW(DW), .LW(LW), .AW(AW), .PAW(PAW)) u_bwd (
    .clk(clk), .rst(rst), .go(go_b), .lg_raddr(b_raddr), .loc_rdata(b_loc_q),
    .gin_rdata(gin_q), .g_we(g_we), .g_waddr(g_waddr), .g_wdata(g_wdata), .fin(b_fin));
endmodule

// File: rtl/mp_pool_chk.sv
module mp_pool_chk #(
  parameter int NPIX = 64,
  parameter int NOUT = 16,
  parameter int DW   = 16,
  parameter int LW   = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          mode,
  input logic          busy,
  input logic          done,
  input logic          f_we,
  input logic [LW-1:0] f_loc,
  input logic          g_we,
  input logic [DW-1:0] g_wdata,
  input logic          b_fin
);
  int wr_cnt;

  always_ff @(posedge clk) begin
    if (rst) wr_cnt <= 0;
    else if (start && !busy && mode) wr_cnt <= 0;
    else if (g_we) wr_cnt <= wr_cnt + 1;
  end

  // R8
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!busy && !done));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R7
  done_end_chk: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && $past(busy)));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst) busy |=> (busy || done));

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (g_we && wr_cnt < NPIX) |-> (g_wdata == '0));

  // R6
  spread_count_chk: assert property (@(posedge clk) disable iff (rst)
    b_fin |-> (g_we && wr_cnt == NPIX + NOUT - 1));

  // R2
  loc_range_chk: assert property (@(posedge clk) disable iff (rst)
    f_we |-> (f_loc < LW'(NPIX)));
endmodule

bind maxpool_argmax mp_pool_chk #(.NPIX(NPIX), .NOUT(NOUT), .DW(DW), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .mode(mode), .busy(busy), .done(done),
  .f_we(f_we), .f_loc(f_loc), .g_we(g_we), .g_wdata(g_wdata), .b_fin(b_fin));

// File: tb/test_maxpool_argmax.sv
module test_maxpool_argmax;
  localparam int W = 8, H = 8, K = 2;
  localparam int OH = H / K;
  localparam int NP = (W / K) * (H / K);
  localparam int NPIX = W * H;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_we = 1'b0, ld_sel = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic        mode = 1'b0, start = 1'b0;
  logic        busy, done;
  logic [3:0]  pool_raddr = '0;
  logic [15:0] pool_q, loc_q;
  logic [5:0]  grad_raddr = '0;
  logic [15:0] grad_q;

  always #4 clk = ~clk;

  maxpool_argmax i_maxpool_argmax (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .mode(mode), .start(start), .busy(busy), .done(done),
    .pool_raddr(pool_raddr), .pool_q(pool_q), .loc_q(loc_q),
    .grad_raddr(grad_raddr), .grad_q(grad_q));

  int src[NPIX];
  int gin[NP];
  int ep[NP];
  int el[NP];
  int eg[NPIX];
  int total = 0;
  int bad = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eidx(input int p, input int n);
    int i = p / OH;
    int j = p % OH;
    return (i * K + n / K) * H + j * K + n % K;
  endfunction

  function automatic void model_fwd();
    for (int p = 0; p < NP; p++) begin
      int m = -999;
      int l = eidx(p, 0);
      for (int n = 0; n < K * K; n++) begin
        if (src[eidx(p, n)] > m) begin
          m = src[eidx(p, n)];
          l = eidx(p, n);
        end
      end
      ep[p] = m;
      el[p] = l;
    end
  endfunction

  function automatic void model_bwd();
    for (int a = 0; a < NPIX; a++) eg[a] = 0;
    for (int p = 0; p < NP; p++) eg[el[p]] = gin[p];
  endfunction

  task automatic ld(input bit sel, input int a, input int d);
    @(negedge clk);
    ld_we = 1'b1;
    ld_sel = sel;
    ld_addr = 6'(a);
    ld_data = 16'(d);
  endtask

  task automatic load_src();
    for (int a = 0; a < NPIX; a++) ld(1'b0, a, src[a]);
    @(negedge clk) ld_we = 1'b0;
  endtask

  task automatic load_gin();
    for (int p = 0; p < NP; p++) begin
      gin[p] = int'($urandom_range(60000)) - 30000;
      ld(1'b1, p, gin[p]);
    end
    @(negedge clk) ld_we = 1'b0;
  endtask

  task automatic run(input bit m, input bit peek);
    int ndone = 0;
    int cyc = 0;
    int prev = -1;
    bit got = 0;
    @(negedge clk);
    mode = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 busy after start", int'(busy), 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!got && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (done) begin
        ndone++;
        got = 1;
      end
      if (peek) begin
        if (prev >= 0) begin
          chk("R9 pooled during backward", int'($signed(pool_q)), ep[prev]);
          chk("R9 location during backward", int'(loc_q), el[prev]);
        end
        prev = cyc % NP;
        pool_raddr = 4'(prev);
      end
    end
    repeat (3) begin
      @(negedge clk);
      if (done) ndone++;
    end
    chk("R7 single done pulse", ndone, 1);
    chk("R7 idle after done", int'(busy), 0);
  endtask

  task automatic check_fwd(input bit directed);
    for (int p = 0; p < NP; p++) begin
      string tv, tl;
      @(negedge clk) pool_raddr = 4'(p);
      @(negedge clk);
      tv = "R1 pooled value";
      tl = "R2 location";
      if (directed && p < 2) begin
        tv = "R3 tie value";
        tl = "R3 tie location";
      end else if (directed && p < 6) begin
        tv = "R4 floor value";
        tl = "R4 floor location";
      end
      chk(tv, int'($signed(pool_q)), ep[p]);
      chk(tl, int'(loc_q), el[p]);
    end
  endtask

  task automatic check_grad();
    for (int a = 0; a < NPIX; a++) begin
      bool_tag: begin
        bit hit = 0;
        for (int p = 0; p < NP; p++) if (el[p] == a) hit = 1;
        @(negedge clk) grad_raddr = 6'(a);
        @(negedge clk);
        if (hit) chk("R6 scattered gradient", int'($signed(grad_q)), eg[a]);
        else     chk("R5 cleared gradient", int'($signed(grad_q)), 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(20240611));
    repeat (3) @(negedge clk);
    chk("R8 busy in reset", int'(busy), 0);
    chk("R8 done in reset", int'(done), 0);
    rst = 1'b0;

    for (int round = 0; round < 3; round++) begin
      for (int a = 0; a < NPIX; a++)
        src[a] = (round == 0) ? int'($urandom_range(1000)) - 500
                              : int'($urandom_range(4000)) - 2000;
      if (round == 0) begin
        for (int n = 0; n < 4; n++) src[eidx(0, n)] = 7;
        src[eidx(1, 0)] = 3;     src[eidx(1, 1)] = 9;
        src[eidx(1, 2)] = 9;     src[eidx(1, 3)] = 1;
        for (int n = 0; n < 4; n++) src[eidx(2, n)] = -1000;
        for (int n = 0; n < 4; n++) src[eidx(3, n)] = -999;
        src[eidx(4, 0)] = -32768; src[eidx(4, 1)] = -999;
        src[eidx(4, 2)] = -1000;  src[eidx(4, 3)] = -2000;
        src[eidx(5, 0)] = -1000;  src[eidx(5, 1)] = -998;
        src[eidx(5, 2)] = -998;   src[eidx(5, 3)] = -5000;
      end
      model_fwd();
      load_src();
      run(1'b0, 1'b0);
      check_fwd(round == 0);

      if (round == 0) begin
        @(negedge clk) pool_raddr = 4'd0;
        @(negedge clk) pool_raddr = 4'd1;
        #1 chk("R10 output held before edge", int'($signed(pool_q)), ep[0]);
        @(negedge clk);
        chk("R10 output after one edge", int'($signed(pool_q)), ep[1]);
      end

      load_gin();
      model_bwd();
      run(1'b1, 1'b1);
      check_grad();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule